// File: doc/BRIEF.md
# Population Count Execution Unit

This execution-stage unit counts the one bits of a 64-bit source operand at an operand size of 16, 32 or 64 bits. The size comes from the decoded prefix state. It returns the zero-extended count as a destination result with a byte-enable mask, and it produces the six arithmetic status flags. In the same pass it decides whether the instruction must raise an invalid-opcode fault. That decision uses the decoded opcode bytes, the lock prefix, the feature-enable bit and whether the core is in 64-bit mode.

Operations enter through a valid/ready handshake and leave through another. The count goes through two registered stages: per-byte counts first, then their sum. One operation can be accepted every cycle while the consumer is ready. Backpressure from the output holds the pipeline in place without losing or reordering operations.

Top module: `popcnt_unit`

## Requirements
- R1: The result equals the number of one bits in `in_src` counted only over the selected size. When `in_rex_w` is 1 the size is 64. Otherwise it is 16 when `in_has_opsz` is 1, and 32 when it is 0. Bits above the size never contribute.
- R2: A good result is zero-extended to 64 bits. `out_wr_be` is 8'h03 for the 16-bit size and 8'hFF for the 32- and 64-bit sizes.
- R3: The zero flag, `out_flags[3]`, is 1 exactly when the size-masked source is zero, which means the count is zero.
- R4: On a good result, `out_flags_we` is 1 and the other flag bits are 0: [0] carry, [1] parity, [2] auxiliary carry, [4] sign and [5] overflow.
- R5: The unit raises a fault unless all three of these hold: `in_has_rep` is 1, `in_esc_0f` is 1 and `in_opcode` is 8'hB8.
- R6: The unit raises a fault when `in_lock` is 1.
- R7: The unit raises a fault when `in_feat_en` is 0.
- R8: The unit raises a fault when `in_rex_w` is 1 and `in_mode64` is 0. The 16- and 32-bit sizes are legal outside 64-bit mode.
- R9: A faulting operation leaves the unit with the following outputs:
  - `out_fault` = 1 and `out_cause` = 8'd6.
  - `out_wr_be` = 0, `out_flags_we` = 0, `out_result` = 0 and `out_flags` = 0.
  - A good operation has `out_fault` = 0 and `out_cause` = 0.
- R10: An input accepted at clock edge k is presented with `out_valid` after edge k+1. While `out_ready` stays high, `in_ready` stays high and an input is accepted every cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. Once both stages are full, `in_ready` drops. Operations leave in acceptance order with none lost.
- R12: A synchronous active-high `rst` empties both stages, so `out_valid` reads 0 and `in_ready` reads 1 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_src | input | 64 | Source operand |
| in_has_rep | input | 1 | F3 prefix present |
| in_esc_0f | input | 1 | 0F escape byte present |
| in_opcode | input | 8 | Primary opcode byte |
| in_has_opsz | input | 1 | Operand-size override prefix present |
| in_rex_w | input | 1 | 64-bit operand request |
| in_lock | input | 1 | Lock prefix present |
| in_mode64 | input | 1 | Core is in 64-bit mode |
| in_feat_en | input | 1 | Population-count feature enabled |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Zero-extended count |
| out_wr_be | output | 8 | Destination byte enables |
| out_flags | output | 6 | {OF,SF,ZF,AF,PF,CF}, bit 0 = CF |
| out_flags_we | output | 1 | Flag write enable |
| out_fault | output | 1 | Operation faults |
| out_cause | output | 8 | Fault cause code |

## Verification
The hardest situation to reach is both stages being full while the output is stalled. In that state `in_ready` must fall, the held result must not move, and a reset must discard both operations. A directed sequence reaches it by dropping `out_ready` and offering inputs until acceptance stops, and then pulsing reset. The random phase adds to this. It toggles `out_ready` and `in_valid` independently, so stalls land on every pipeline occupancy. Meanwhile the bench matches each result in order against a software count.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  typedef enum logic [1:0] {
    OSZ_16 = 2'd0,
    OSZ_32 = 2'd1,
    OSZ_64 = 2'd2
  } op_size_e;

  localparam int NFLAGS = 6;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;

  localparam logic [7:0] OPC_MAIN         = 8'hB8;
  localparam logic [7:0] CAUSE_NONE       = 8'd0;
  localparam logic [7:0] CAUSE_INVALID_OP = 8'd6;

endpackage

// File: rtl/popcnt_fault_chk.sv
module popcnt_fault_chk
  import popcnt_pkg::*;
(
  input  logic       has_rep,
  input  logic       esc_0f,
  input  logic [7:0] opcode,
  input  logic       has_opsz,
  input  logic       rex_w,
  input  logic       lock,
  input  logic       mode64,
  input  logic       feat_en,
  output op_size_e   size,
  output logic       fault
);

  logic opc_match;
  logic wide_illegal;

  always_comb begin
    if (rex_w)         size = OSZ_64;
    else if (has_opsz) size = OSZ_16;
    else               size = OSZ_32;
  end

  assign opc_match    = has_rep && esc_0f && (opcode == OPC_MAIN);
  assign wide_illegal = rex_w && !mode64;
  assign fault        = !opc_match || lock || !feat_en || wide_illegal;

endmodule

// File: rtl/popcnt_byte_cnt.sv
module popcnt_byte_cnt
  import popcnt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int BC_W  = $clog2(BYTE_W + 1)
) (
  input  logic [DATA_W-1:0]        src,
  input  op_size_e                 size,
  output logic [NB-1:0][BC_W-1:0]  cnt,
  output logic                     nonzero
);

  logic [NB-1:0] keep;
  logic [NB-1:0] byte_nz;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      case (size)
        OSZ_16:  keep[b] = (b < 2);
        OSZ_32:  keep[b] = (b < 4);
        default: keep[b] = 1'b1;
      endcase
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BYTE_W-1:0] lane;
    logic [BC_W-1:0]   acc;

    assign lane = keep[g] ? src[g*BYTE_W +: BYTE_W] : '0;

    always_comb begin
      acc = '0;
      for (int k = 0; k < BYTE_W; k++) begin
        acc = acc + {{(BC_W-1){1'b0}}, lane[k]};
      end
    end

    assign cnt[g]     = acc;
    assign byte_nz[g] = |lane;
  end

  assign nonzero = |byte_nz;

endmodule

// File: rtl/popcnt_byte_sum.sv
module popcnt_byte_sum #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB    = DATA_W / BYTE_W,
  localparam int BC_W  = $clog2(BYTE_W + 1),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [NB-1:0][BC_W-1:0] cnt,
  output logic [CNT_W-1:0]        total
);

  always_comb begin
    total = '0;
    for (int i = 0; i < NB; i++) begin
      total = total + CNT_W'(cnt[i]);
    end
  end

endmodule

// File: rtl/popcnt_unit.sv
module popcnt_unit
  import popcnt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DATA_W-1:0]        in_src,
  input  logic                     in_has_rep,
  input  logic                     in_esc_0f,
  input  logic [7:0]               in_opcode,
  input  logic                     in_has_opsz,
  input  logic                     in_rex_w,
  input  logic                     in_lock,
  input  logic                     in_mode64,
  input  logic                     in_feat_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_result,
  output logic [DATA_W/BYTE_W-1:0] out_wr_be,
  output logic [5:0]               out_flags,
  output logic                     out_flags_we,
  output logic                     out_fault,
  output logic [7:0]               out_cause
);

  localparam int NB    = DATA_W / BYTE_W;
  localparam int BC_W  = $clog2(BYTE_W + 1);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [NB-1:0] BE_NARROW = NB'(2'b11);

  op_size_e                 dec_size;
  logic                     dec_fault;
  logic [NB-1:0][BC_W-1:0]  st0_cnt;
  logic                     st0_nz;

  logic                     s1_valid;
  logic [NB-1:0][BC_W-1:0]  s1_cnt;
  logic                     s1_nz;
  logic                     s1_fault;
  logic                     s1_narrow;

  logic [CNT_W-1:0]         s1_total;
  logic                     out_take;

  popcnt_fault_chk u_fault (
    .has_rep  (in_has_rep),
    .esc_0f   (in_esc_0f),
    .opcode   (in_opcode),
    .has_opsz (in_has_opsz),
    .rex_w    (in_rex_w),
    .lock     (in_lock),
    .mode64   (in_mode64),
    .feat_en  (in_feat_en),
    .size     (dec_size),
    .fault    (dec_fault)
  );

  popcnt_byte_cnt #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bytes (
    .src     (in_src),
    .size    (dec_size),
    .cnt     (st0_cnt),
    .nonzero (st0_nz)
  );

  popcnt_byte_sum #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_sum (
    .cnt   (s1_cnt),
    .total (s1_total)
  );

  assign out_take = !out_valid || out_ready;
  assign in_ready = !s1_valid || out_take;

  // stage 1: per-byte counts
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_cnt    <= st0_cnt;
      s1_nz     <= st0_nz;
      s1_fault  <= dec_fault;
      s1_narrow <= (dec_size == OSZ_16);
    end
  end

  // stage 2: summed result, flags and fault outcome
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (out_take) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (out_take && s1_valid) begin
      out_fault <= s1_fault;
      if (s1_fault) begin
        out_result   <= '0;
        out_wr_be    <= '0;
        out_flags    <= '0;
        out_flags_we <= 1'b0;
        out_cause    <= CAUSE_INVALID_OP;
      end else begin
        out_result           <= {{(DATA_W-CNT_W){1'b0}}, s1_total};
        out_wr_be            <= s1_narrow ? BE_NARROW : '1;
        out_flags            <= '0;
        out_flags[FLG_ZF]    <= !s1_nz;
        out_flags_we         <= 1'b1;
        out_cause            <= CAUSE_NONE;
      end
    end
  end

endmodule

// File: rtl/popcnt_unit_chk.sv
module popcnt_unit_chk
  import popcnt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [DATA_W-1:0]        out_result,
  input logic [DATA_W/BYTE_W-1:0] out_wr_be,
  input logic [5:0]               out_flags,
  input logic                     out_flags_we,
  input logic                     out_fault,
  input logic [7:0]               out_cause
);

  localparam logic [5:0] ZF_BIT = 6'd1 << FLG_ZF;

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault && (out_wr_be == (DATA_W/BYTE_W)'(2'b11)) |-> out_result <= DATA_W'(16)); // R1

  AST_ZF_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault |-> out_flags[FLG_ZF] == (out_result == '0)); // R3

  AST_OTHER_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags & ~ZF_BIT) == 6'd0); // R4

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_fault |-> (out_wr_be == '0) && !out_flags_we && (out_cause == CAUSE_INVALID_OP)); // R9

  AST_GOOD_WRITES: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault |-> out_flags_we && (out_wr_be != '0)); // R2

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_fault) && $stable(out_flags)); // R11

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R10

endmodule

bind popcnt_unit popcnt_unit_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_result   (out_result),
  .out_wr_be    (out_wr_be),
  .out_flags    (out_flags),
  .out_flags_we (out_flags_we),
  .out_fault    (out_fault),
  .out_cause    (out_cause)
);

// File: tb/tb_popcnt_unit.sv
`timescale 1ns/1ps
module tb_popcnt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic        in_has_rep = 1'b0, in_esc_0f = 1'b0, in_has_opsz = 1'b0;
  logic [7:0]  in_opcode = '0;
  logic        in_rex_w = 1'b0, in_lock = 1'b0, in_mode64 = 1'b0, in_feat_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic [7:0]  out_wr_be;
  logic [5:0]  out_flags;
  logic        out_flags_we, out_fault;
  logic [7:0]  out_cause;

  always #10 clk = ~clk;

  popcnt_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_has_rep(in_has_rep), .in_esc_0f(in_esc_0f), .in_opcode(in_opcode),
    .in_has_opsz(in_has_opsz), .in_rex_w(in_rex_w), .in_lock(in_lock),
    .in_mode64(in_mode64), .in_feat_en(in_feat_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_wr_be(out_wr_be),
    .out_flags(out_flags), .out_flags_we(out_flags_we), .out_fault(out_fault),
    .out_cause(out_cause)
  );

  typedef struct {
    logic [63:0] src;
    logic rep, esc, opsz, rexw, lock, m64, feat;
    logic [7:0] opc;
  } op_t;

  typedef struct {
    logic [63:0] res;
    logic [7:0]  be;
    logic [5:0]  flg;
    logic        we, flt;
    logic [7:0]  cause;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          lat_mode = 0, done = 0;
  bit          held = 0;
  logic [63:0] held_res;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic op_t mk(logic [63:0] src, int sz);
    op_t o;
    o.src = src; o.rep = 1; o.esc = 1; o.opc = 8'hB8;
    o.opsz = (sz == 16); o.rexw = (sz == 64);
    o.lock = 0; o.m64 = 1; o.feat = 1;
    return o;
  endfunction

  function automatic exp_t model(op_t o, string tag);
    exp_t e;
    bit   f;
    int   n, c;
    f = !(o.rep && o.esc && o.opc == 8'hB8) || o.lock || !o.feat || (o.rexw && !o.m64);
    n = o.rexw ? 64 : (o.opsz ? 16 : 32);
    c = 0;
    for (int i = 0; i < n; i++) c += int'(o.src[i]);
    e.flt   = f;
    e.cause = f ? 8'd6 : 8'd0;
    e.res   = f ? 64'd0 : 64'(c);
    e.be    = f ? 8'h00 : ((n == 16) ? 8'h03 : 8'hFF);
    e.we    = !f;
    e.flg   = (!f && c == 0) ? 6'b001000 : 6'b000000;
    e.tag   = tag;
    e.cyc   = 0;
    return e;
  endfunction

  task automatic step(op_t o, bit v, bit ordy, string tag);
    exp_t e;
    @(negedge clk);
    cyc++;
    out_ready = ordy;
    #1;
    if (held) begin
      chk(out_valid == 1'b1, "R11", "held valid", 64'(out_valid), 64'd1);
      chk(out_result == held_res, "R11", "held result", out_result, held_res);
      held = 0;
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(0, "R11", "unexpected output", out_result, 64'd0);
      end else begin
        e = q.pop_front();
        chk(out_result == e.res && out_wr_be == e.be && out_flags == e.flg &&
            out_flags_we == e.we && out_fault == e.flt && out_cause == e.cause,
            e.tag, "result/be/flags/we/fault/cause",
            {out_result[39:0], out_wr_be, out_flags, out_flags_we, out_fault, out_cause},
            {e.res[39:0], e.be, e.flg, e.we, e.flt, e.cause});
        if (lat_mode) chk(cyc - e.cyc == 2, "R10", "latency", 64'(cyc - e.cyc), 64'd2);
      end
    end
    if (out_valid && !out_ready) begin
      held = 1;
      held_res = out_result;
    end
    in_valid = v;
    in_src = o.src; in_has_rep = o.rep; in_esc_0f = o.esc; in_opcode = o.opc;
    in_has_opsz = o.opsz; in_rex_w = o.rexw; in_lock = o.lock;
    in_mode64 = o.m64; in_feat_en = o.feat;
    #1;
    if (lat_mode) chk(in_ready == 1'b1, "R10", "in_ready", 64'(in_ready), 64'd1);
    if (v && in_ready) begin
      e = model(o, tag);
      e.cyc = cyc;
      q.push_back(e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    q.delete();
    held = 0;
    #1;
    chk(out_valid == 1'b0, "R12", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(mk(64'd0, 32), 0, 1, "R11");
    chk(q.size() == 0, "R11", "queue empty", 64'(q.size()), 64'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    op_t o;
    int  sz, r;
    void'($urandom(32'd20240611));
    do_reset();

    // directed corners: R1 R2 R3 R4
    lat_mode = 1;
    for (int s = 0; s < 3; s++) begin
      sz = (s == 0) ? 16 : (s == 1) ? 32 : 64;
      step(mk(64'd0, sz), 1, 1, "R3");
      step(mk('1, sz), 1, 1, "R2");
      for (int b = 0; b < sz; b++) step(mk(64'd1 << b, sz), 1, 1, "R1");
    end
    step(mk(64'hFFFF_FFFF_FFFF_0000, 16), 1, 1, "R1");
    step(mk(64'd1 << 40, 32), 1, 1, "R3");
    step(mk(64'h8000_0000_0000_0001, 64), 1, 1, "R4");

    // fault conditions: R5 R6 R7 R8 R9
    o = mk(64'hFF, 32); o.opc = 8'hB9;  step(o, 1, 1, "R5");
    o = mk(64'hFF, 32); o.rep = 0;      step(o, 1, 1, "R5");
    o = mk(64'hFF, 32); o.esc = 0;      step(o, 1, 1, "R5");
    o = mk(64'hFF, 64); o.lock = 1;     step(o, 1, 1, "R6");
    o = mk(64'hFF, 16); o.feat = 0;     step(o, 1, 1, "R7");
    o = mk(64'hFF, 64); o.m64 = 0;      step(o, 1, 1, "R8");
    o = mk(64'hFF, 32); o.m64 = 0;      step(o, 1, 1, "R8");
    o = mk(64'hFF0F, 16); o.m64 = 0;    step(o, 1, 1, "R8");
    o = mk(64'd0, 64); o.lock = 1;      step(o, 1, 1, "R9");
    drain();
    lat_mode = 0;

    // full pipeline under stall, then reset: R11 R12
    step(mk(64'd3, 32), 1, 0, "R11");
    step(mk(64'd7, 32), 1, 0, "R11");
    step(mk(64'd15, 32), 1, 0, "R11");
    chk(in_ready == 1'b0, "R11", "in_ready when full", 64'(in_ready), 64'd0);
    step(mk(64'd15, 32), 1, 0, "R11");
    do_reset();
    drain();

    // constrained random with backpressure
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 3);
      sz = (r == 0) ? 16 : (r == 1) ? 32 : 64;
      o = mk({$urandom, $urandom}, sz);
      if ($urandom % 4 == 0) o.src = o.src & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 10 == 0) begin
        case ($urandom % 5)
          0: o.lock = 1;
          1: o.feat = 0;
          2: o.m64 = 0;
          3: o.opc = 8'(int'($urandom));
          default: o.rep = 0;
        endcase
      end
      step(o, ($urandom % 5) != 0, ($urandom % 10) < 7, "R1");
    end
    drain();

    done = 1;
    summary();
  end

endmodule